// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches a word carried in dual-rail form, where each bit travels on a true rail and a false rail. When exactly one rail of a bit is high, the bit holds a value. When both rails are low or both are high, the bit is in a spacer state and holds no value. A correct stream moves back and forth between a full spacer and a full codeword. It never goes straight from one codeword to the next. The block supports both spacer polarities used by a double-spacer scheme, so the spacer after one codeword can be all-low and the spacer after the next can be all-high.

Completion is found by a tree of state-holding C-element cells. Each cell goes high only when all of its inputs are high, goes low only when all of its inputs are low, and otherwise keeps its value. A sampling clock updates the cells. Each cell's next state is worked out from the next states of its children, so the whole tree settles within one sampling cycle. The tree drives a `done` output and a one-cycle `latchEn` pulse that a downstream register can use to capture `dataOut`.

A per-bit mask swaps the true and false rails, which inverts that bit without any inverter. A sticky error flag records two protocol faults: a direct flip between codewords, and a spacer of the wrong polarity.

Top module: `dualrail_completion`

## Requirements
- R1: `dataOut[i]` equals `railF[i]` when `invMask[i]` is 1 and `railT[i]` when it is 0. For a valid bit this is the bit value XOR the mask bit.
- R2: One sampling cycle after every bit holds exactly one high rail, `done` is 1.
- R3: One sampling cycle after every bit sits in the selected spacer, `done` is 0. The selected spacer is both rails low when `spacerSel` is 0 and both rails high when `spacerSel` is 1.
- R4: When some bits are valid and others are in a spacer, `done` keeps its previous value. A bit in the non-selected spacer also leaves `done` unchanged.
- R5: `latchEn` is 1 for exactly one cycle: the first cycle in which `done` is 1.
- R6: If a bit that was valid in the previous cycle is valid again with the opposite value, with no spacer in between, `protoErr` is 1 from the next cycle.
- R7: If any bit shows the spacer polarity that `spacerSel` does not select, `protoErr` is 1 from the next cycle.
- R8: `protoErr` stays at 1 until a synchronous active-high `rst`. Reset clears `done`, `latchEn`, `protoErr` and all tree state to 0.
- R9: The tree reduces the per-bit cells four at a time per level. A width of `N` bits (1 to 64) still gives a single-cycle `done` response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| railT | input | N | True rail of each bit |
| railF | input | N | False rail of each bit |
| invMask | input | N | Per-bit rail swap (logical inversion) |
| spacerSel | input | 1 | Expected spacer: 0 all-low, 1 all-high |
| done | output | 1 | Word complete (codeword fully arrived) |
| latchEn | output | 1 | One-cycle capture pulse on completion |
| dataOut | output | N | Decoded word after rail swap |
| protoErr | output | 1 | Sticky protocol violation flag |

## Verification
The assertions take for granted that the rails are stable for a whole sampling period. They also assume that `spacerSel` changes only while the word is a complete codeword, and that `invMask` does not change within a codeword. Under those assumptions, any spacer the block sees can be judged against the current selection. The bench drives every input on the falling clock edge, changes `spacerSel` only after `done` has risen, and keeps the mask fixed for each word. Faults are injected on purpose only inside the error scenarios, and each of those scenarios ends with a reset.

// File: rtl/dualrail_pkg.sv
package dualrail_pkg;

  // Status lines from the datapath to the control.
  typedef struct packed {
    logic treeDone;     // root of the C-element tree
    logic flipSeen;     // codeword-to-codeword change this cycle
    logic wrongSpacer;  // non-selected spacer polarity present
  } dpStatus_t;

  // Number of four-way reduction levels above the leaf cells.
  function automatic int treeLevels(int n);
    int w;
    int l;
    w = n;
    l = 0;
    while (w > 1) begin
      w = (w + 3) / 4;
      l++;
    end
    return l;
  endfunction

  // Node count at a given level (level 0 = leaves).
  function automatic int levelWidth(int n, int lvl);
    int w;
    w = n;
    for (int k = 0; k < lvl; k++) w = (w + 3) / 4;
    return w;
  endfunction

endpackage

// File: rtl/dualrail_datapath.sv
module dualrail_datapath
  import dualrail_pkg::*;
#(
  parameter int N = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    railT,
  input  logic [N-1:0]    railF,
  input  logic [N-1:0]    invMask,
  input  logic            spacerSel,
  output logic [N-1:0]    dataOut,
  output dpStatus_t       status
);

  localparam int LEVELS = treeLevels(N);
  localparam int FANIN  = 4;

  // Rail swap implements inversion.
  logic [N-1:0] trueRail, falseRail;
  assign trueRail  = (railT & ~invMask) | (railF & invMask);
  assign falseRail = (railF & ~invMask) | (railT & invMask);
  assign dataOut   = trueRail;

  // Per-bit classification.
  logic [N-1:0] bitValid, atZero, atOne, atSel, atOther;
  assign bitValid = trueRail ^ falseRail;
  assign atZero   = ~(trueRail | falseRail);
  assign atOne    = trueRail & falseRail;
  assign atSel    = spacerSel ? atOne  : atZero;
  assign atOther  = spacerSel ? atZero : atOne;

  // Previous codeword tracking for flip detection.
  logic [N-1:0] prevValid, prevTrue;
  logic         flipNow;
  assign flipNow = |(prevValid & bitValid & (prevTrue ^ trueRail));

  // C-element tree: state per level, next state cascaded from children.
  logic [N-1:0] lvlNext [0:LEVELS];
  logic [N-1:0] lvlQ    [0:LEVELS];

  // Leaf cell per bit: inputs are "valid" and "not at selected spacer".
  for (genvar i = 0; i < N; i++) begin : g_leaf
    logic inA, inB;
    assign inA = bitValid[i];
    assign inB = ~atSel[i];
    assign lvlNext[0][i] = (inA & inB) | (lvlQ[0][i] & (inA | inB));
  end

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int WPREV = levelWidth(N, l - 1);
    localparam int WCUR  = levelWidth(N, l);
    for (genvar j = 0; j < N; j++) begin : g_node
      if (j < WCUR) begin : g_used
        logic [FANIN-1:0] kids;
        for (genvar k = 0; k < FANIN; k++) begin : g_kid
          if (FANIN * j + k < WPREV) begin : g_real
            assign kids[k] = lvlNext[l-1][FANIN*j+k];
          end else begin : g_pad
            assign kids[k] = lvlNext[l-1][FANIN*j];
          end
        end
        assign lvlNext[l][j] = (&kids) | (lvlQ[l][j] & (|kids));
      end else begin : g_none
        assign lvlNext[l][j] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l <= LEVELS; l++) begin
      lvlQ[l] <= rst ? '0 : lvlNext[l];
    end
    if (rst) begin
      prevValid <= '0;
      prevTrue  <= '0;
    end else begin
      prevValid <= bitValid;
      prevTrue  <= trueRail;
    end
  end

  assign status.treeDone    = lvlQ[LEVELS][0];
  assign status.flipSeen    = flipNow;
  assign status.wrongSpacer = |atOther;

endmodule

// File: rtl/dualrail_control.sv
module dualrail_control
  import dualrail_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  dpStatus_t status,
  output logic      done,
  output logic      latchEn,
  output logic      protoErr
);

  logic doneD;
  logic errQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      doneD <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      doneD <= status.treeDone;
      errQ  <= errQ | status.flipSeen | status.wrongSpacer;
    end
  end

  assign done     = status.treeDone;
  assign latchEn  = status.treeDone & ~doneD;
  assign protoErr = errQ;

endmodule

// File: rtl/dualrail_completion.sv
module dualrail_completion
  import dualrail_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] railT,
  input  logic [N-1:0] railF,
  input  logic [N-1:0] invMask,
  input  logic         spacerSel,
  output logic         done,
  output logic         latchEn,
  output logic [N-1:0] dataOut,
  output logic         protoErr
);

  dpStatus_t dpStatus;

  dualrail_datapath #(.N(N)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .railT     (railT),
    .railF     (railF),
    .invMask   (invMask),
    .spacerSel (spacerSel),
    .dataOut   (dataOut),
    .status    (dpStatus)
  );

  dualrail_control u_ctl (
    .clk      (clk),
    .rst      (rst),
    .status   (dpStatus),
    .done     (done),
    .latchEn  (latchEn),
    .protoErr (protoErr)
  );

endmodule

// File: rtl/dualrail_completion_chk.sv
module dualrail_completion_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] railT,
  input logic [N-1:0] railF,
  input logic         spacerSel,
  input logic         done,
  input logic         latchEn,
  input logic         protoErr
);

  logic allValid, allSel, wrongSp;
  logic [N-1:0] validV;
  assign validV   = railT ^ railF;
  assign allValid = &validV;
  assign allSel   = spacerSel ? &(railT & railF) : &(~(railT | railF));
  assign wrongSp  = spacerSel ? |(~(railT | railF)) : |(railT & railF);

  // R2
  rise_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(allValid));

  // R3
  fall_after_spacer_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(allSel));

  // R4
  hold_when_mixed_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!allValid && !allSel)) |-> (done == $past(done)));

  // R5
  latch_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    latchEn |-> done);

  // R5
  latch_single_chk: assert property (@(posedge clk) disable iff (rst)
    latchEn |=> !latchEn);

  // R6
  flip_flags_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && |($past(validV) & validV & ($past(railT) ^ railT))) |=> protoErr);

  // R7
  wrong_spacer_chk: assert property (@(posedge clk) disable iff (rst)
    wrongSp |=> protoErr);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    protoErr |=> protoErr);

endmodule

bind dualrail_completion dualrail_completion_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .railT     (railT),
  .railF     (railF),
  .spacerSel (spacerSel),
  .done      (done),
  .latchEn   (latchEn),
  .protoErr  (protoErr)
);

// File: tb/dualrail_completion_tb.sv
module dualrail_completion_tb;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] railT = '0;
  logic [N-1:0] railF = '0;
  logic [N-1:0] invMask = '0;
  logic         spacerSel = 1'b0;
  logic         done, latchEn, protoErr;
  logic [N-1:0] dataOut;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #4 clk = ~clk;   // 125 MHz

  dualrail_completion #(.N(N)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .railT     (railT),
    .railF     (railF),
    .invMask   (invMask),
    .spacerSel (spacerSel),
    .done      (done),
    .latchEn   (latchEn),
    .dataOut   (dataOut),
    .protoErr  (protoErr)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic putWord(logic [N-1:0] d);
    railT = d;
    railF = ~d;
    step();
  endtask

  task automatic putSpacer(logic pol);
    railT = {N{pol}};
    railF = {N{pol}};
    step();
  endtask

  task automatic doReset();
    rst = 1'b1;
    railT = '0;
    railF = '0;
    invMask = '0;
    spacerSel = 1'b0;
    step();
    step();
    rst = 1'b0;
    step();
  endtask

  task automatic testReset();
    chk("R8 done after reset", done, 0);
    chk("R8 latchEn after reset", latchEn, 0);
    chk("R8 protoErr after reset", protoErr, 0);
  endtask

  task automatic testDoubleSpacer();
    spacerSel = 1'b0;
    putWord(8'hA5);
    chk("R2 done on word", done, 1);
    chk("R5 latchEn pulse", latchEn, 1);
    chk("R1 dataOut", dataOut, 8'hA5);
    step();
    chk("R5 latchEn one cycle", latchEn, 0);
    chk("R2 done held", done, 1);
    spacerSel = 1'b1;
    putSpacer(1'b1);
    chk("R3 done falls at ones spacer", done, 0);
    putWord(8'h3C);
    chk("R2 done second word", done, 1);
    chk("R5 latchEn second word", latchEn, 1);
    spacerSel = 1'b0;
    putSpacer(1'b0);
    chk("R3 done falls at zeros spacer", done, 0);
    chk("R7 no error on good stream", protoErr, 0);
  endtask

  task automatic testMixed();
    spacerSel = 1'b0;
    railT = 8'h05;
    railF = 8'h0A;
    step();
    chk("R4 done holds low when half valid", done, 0);
    chk("R5 no latch while mixed", latchEn, 0);
    putWord(8'h65);
    chk("R2 done after rest valid", done, 1);
    railT = 8'h60;
    railF = 8'h80;
    step();
    chk("R4 done holds high when half spacer", done, 1);
    putSpacer(1'b0);
    chk("R3 done low after full spacer", done, 0);
    chk("R4 mixed is not an error", protoErr, 0);
  endtask

  task automatic testInvert();
    invMask = 8'h0F;
    putWord(8'h5A);
    chk("R1 swapped rails in dataOut", dataOut, 8'h55);
    chk("R1 done with swapped rails", done, 1);
    putSpacer(1'b0);
    chk("R1 spacer with mask", done, 0);
    invMask = 8'h00;
  endtask

  task automatic testFlip();
    spacerSel = 1'b0;
    putWord(8'h11);
    chk("R6 no error before flip", protoErr, 0);
    putWord(8'h10);
    chk("R6 flip flagged", protoErr, 1);
    putSpacer(1'b0);
    putSpacer(1'b0);
    chk("R8 error sticky", protoErr, 1);
    doReset();
    chk("R8 error cleared by reset", protoErr, 0);
  endtask

  task automatic testWrongSpacer();
    spacerSel = 1'b0;
    putWord(8'hC3);
    chk("R7 done before bad spacer", done, 1);
    putSpacer(1'b1);
    chk("R7 wrong spacer flagged", protoErr, 1);
    chk("R4 done holds on wrong spacer", done, 1);
    doReset();
    chk("R8 done cleared by reset", done, 0);
  endtask

  task automatic testWidth();
    // R9: single-cycle response through a two-level tree at N=8
    putWord(8'hFF);
    chk("R9 done one cycle through tree", done, 1);
    putSpacer(1'b0);
    chk("R9 release one cycle through tree", done, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    doReset();
    testReset();
    testDoubleSpacer();
    testMixed();
    testInvert();
    testWidth();
    testFlip();
    testWrongSpacer();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule